// File: doc/BRIEF.md
# Multichannel Audio DMA Pointer Engine

This block generates addresses for a set of playback and record DMA channels. Every channel works on a circular buffer described by a base address, a byte size and a running byte offset. Each sample-frame strobe on a running channel moves its offset forward by one frame, and the offset returns to zero at the end of the buffer. The block also presents the current address of every channel, which is the base plus the offset, to the bus master that moves the samples.

Software reaches all channel registers through a two-port indirect window. It first writes a pointer word that selects a register and a channel, then reads or writes the data port. Events at the halfway point and at the end of each buffer go into one audio status word, where software clears them by writing 1s. When any enabled event is pending, a summary bit is set in a global status register. That summary bit, masked by a global enable register, drives the interrupt line. The defaults give four playback and four record channels, which is also the maximum: each event group has four bits.

Top module: `audio_ptr_engine`

## Requirements
- R1: bus_addr 0 is the pointer register: bits 31:16 select the register and bits 15:0 select the channel. It reads back as written. bus_addr 1 is the data port. Register numbers: playback base 0x0, playback size 0x1, playback offset 0x2, record base 0x4, record size 0x5, record offset 0x6, run 0x10, audio enable 0x11, audio status 0x12. A register number that is not listed, or a channel index outside the channel count, reads 0 and ignores writes.
- R2: A size register keeps only data bits 31:16, as a byte count, and its low half reads 0. An offset register reads the offset in bits 15:0. A data write sets the offset, and it takes priority over an advance in the same cycle.
- R3: On a frame strobe, a running channel advances its offset by 4 bytes. Each channel's address output equals its base plus its offset.
- R4: In the run register, bit n runs playback channel n and bit 8+n runs record channel n. A channel whose bit is 0 keeps its offset, whatever its strobe does.
- R5: An advance that moves the offset from below size/2 to size/2 or above sets the half flag. This is status bit n for playback channel n and bit 16+n for record channel n.
- R6: When offset+4 reaches or passes the size, the offset becomes 0 and the full flag is set. This is status bit 4+n for playback and bit 20+n for record.
- R7: Status flags stay set until cleared. Each 1 written to the status register clears that bit, and each 0 leaves its bit unchanged. An event in the same cycle wins over the clear. Flags are recorded whether or not they are enabled.
- R8: Global status bit 8 (bus_addr 2) becomes 1 one cycle after any status bit whose enable bit is set. Writing 1 to bit 8 clears it only while nothing enabled is pending. All other bits read 0.
- R9: The global enable register (bus_addr 3) is a 32-bit read/write register. irq is high exactly when global status bit 8 and global enable bit 8 are both set.
- R10: After reset every register, every offset, every address output and irq are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | 0 pointer, 1 data, 2 global status, 3 global enable |
| bus_wr | input | 1 | Write strobe for bus_addr |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| play_tick | input | NP | Frame strobe per playback channel |
| rec_tick | input | NR | Frame strobe per record channel |
| play_addr | output | 32*NP | Current address per playback channel |
| rec_addr | output | 32*NR | Current address per record channel |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is the interaction between the sticky summary bit and an audio flag that is still pending. Software tries to clear global status while an enabled full flag remains set. It then clears the flag through the window, and only after that does a second global clear take effect. The stimulus walks a small 16-byte playback buffer through its half and full points with single strobes. It then performs the clears in that order, reading global status and irq after each step. A record channel is run through a complete wrap with its events left disabled, which shows that the flags are recorded while irq stays low. A reference model in the bench tracks every register and offset and is compared with the outputs on every cycle.

// File: rtl/audio_ptr_engine.sv
module audio_ptr_engine #(
  parameter int NP = 4,
  parameter int NR = 4,
  parameter int FRAME_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NP-1:0]    play_tick,
  input  logic [NR-1:0]    rec_tick,
  output logic [NP*32-1:0] play_addr,
  output logic [NR*32-1:0] rec_addr,
  output logic             irq
);
  localparam logic [15:0] R_PBASE = 16'h0000;
  localparam logic [15:0] R_PSIZE = 16'h0001;
  localparam logic [15:0] R_POFS  = 16'h0002;
  localparam logic [15:0] R_RBASE = 16'h0004;
  localparam logic [15:0] R_RSIZE = 16'h0005;
  localparam logic [15:0] R_ROFS  = 16'h0006;
  localparam logic [15:0] R_RUN   = 16'h0010;
  localparam logic [15:0] R_IEN   = 16'h0011;
  localparam logic [15:0] R_IST   = 16'h0012;
  localparam int PH = 0;
  localparam int PF = 4;
  localparam int RH = 16;
  localparam int RF = 20;
  localparam logic [31:0] PMASK = (32'd1 << NP) - 32'd1;
  localparam logic [31:0] RMASK = (32'd1 << NR) - 32'd1;
  localparam logic [31:0] VMASK = (PMASK << PH) | (PMASK << PF) | (RMASK << RH) | (RMASK << RF);

  logic [31:0] ptr, gen, ais, aie, evt, data_rd, run_word, gstat;
  logic        gsum;
  logic [NP-1:0] prun;
  logic [NR-1:0] rrun;
  logic [31:0] pbase [NP];
  logic [15:0] psize [NP];
  logic [15:0] pofs  [NP];
  logic [17:0] pstep [NP];
  logic [31:0] rbase [NR];
  logic [15:0] rsize [NR];
  logic [15:0] rofs  [NR];
  logic [17:0] rstep [NR];

  wire [15:0] sel_reg = ptr[31:16];
  wire [15:0] sel_ch  = ptr[15:0];
  wire        dwr     = bus_wr && (bus_addr == 2'd1);
  wire        gclr    = bus_wr && (bus_addr == 2'd2) && bus_wdata[8];

  function automatic logic [17:0] step(input logic [15:0] ofs, input logic [15:0] size);
    logic [16:0] n;
    logic [15:0] h;
    logic [17:0] r;
    n = {1'b0, ofs} + 17'(FRAME_BYTES);
    h = size >> 1;
    r[17] = (ofs < h) && (n >= {1'b0, h});
    r[16] = n >= {1'b0, size};
    r[15:0] = r[16] ? 16'd0 : n[15:0];
    return r;
  endfunction

  assign run_word = 32'(prun) | (32'(rrun) << 8);
  assign gstat    = {23'd0, gsum, 8'd0};
  assign irq      = |(gstat & gen);

  always_comb begin
    evt = '0;
    for (int i = 0; i < NP; i++) begin
      pstep[i] = step(pofs[i], psize[i]);
      evt[PH+i] = prun[i] && play_tick[i] && pstep[i][17];
      evt[PF+i] = prun[i] && play_tick[i] && pstep[i][16];
    end
    for (int i = 0; i < NR; i++) begin
      rstep[i] = step(rofs[i], rsize[i]);
      evt[RH+i] = rrun[i] && rec_tick[i] && rstep[i][17];
      evt[RF+i] = rrun[i] && rec_tick[i] && rstep[i][16];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      gen  <= '0;
      ais  <= '0;
      aie  <= '0;
      gsum <= 1'b0;
      prun <= '0;
      rrun <= '0;
      for (int i = 0; i < NP; i++) begin
        pbase[i] <= '0; psize[i] <= '0; pofs[i] <= '0;
      end
      for (int i = 0; i < NR; i++) begin
        rbase[i] <= '0; rsize[i] <= '0; rofs[i] <= '0;
      end
    end else begin
      if (bus_wr && bus_addr == 2'd0) ptr <= bus_wdata;
      if (bus_wr && bus_addr == 2'd3) gen <= bus_wdata;
      gsum <= (gsum && !gclr) || (|(ais & aie));
      ais  <= (ais & ~((dwr && sel_reg == R_IST) ? bus_wdata : 32'd0)) | evt;
      if (dwr && sel_reg == R_IEN) aie <= bus_wdata & VMASK;
      if (dwr && sel_reg == R_RUN) begin
        prun <= bus_wdata[NP-1:0];
        rrun <= bus_wdata[8 +: NR];
      end
      for (int i = 0; i < NP; i++) begin
        if (prun[i] && play_tick[i]) pofs[i] <= pstep[i][15:0];
        if (dwr && sel_ch == 16'(i)) begin
          if (sel_reg == R_PBASE) pbase[i] <= bus_wdata;
          if (sel_reg == R_PSIZE) psize[i] <= bus_wdata[31:16];
          if (sel_reg == R_POFS)  pofs[i]  <= bus_wdata[15:0];
        end
      end
      for (int i = 0; i < NR; i++) begin
        if (rrun[i] && rec_tick[i]) rofs[i] <= rstep[i][15:0];
        if (dwr && sel_ch == 16'(i)) begin
          if (sel_reg == R_RBASE) rbase[i] <= bus_wdata;
          if (sel_reg == R_RSIZE) rsize[i] <= bus_wdata[31:16];
          if (sel_reg == R_ROFS)  rofs[i]  <= bus_wdata[15:0];
        end
      end
    end
  end

  always_comb begin
    data_rd = '0;
    case (sel_reg)
      R_RUN:   data_rd = run_word;
      R_IEN:   data_rd = aie;
      R_IST:   data_rd = ais;
      default: ;
    endcase
    for (int i = 0; i < NP; i++) begin
      if (sel_ch == 16'(i)) begin
        case (sel_reg)
          R_PBASE: data_rd = pbase[i];
          R_PSIZE: data_rd = {psize[i], 16'h0};
          R_POFS:  data_rd = {16'h0, pofs[i]};
          default: ;
        endcase
      end
    end
    for (int i = 0; i < NR; i++) begin
      if (sel_ch == 16'(i)) begin
        case (sel_reg)
          R_RBASE: data_rd = rbase[i];
          R_RSIZE: data_rd = {rsize[i], 16'h0};
          R_ROFS:  data_rd = {16'h0, rofs[i]};
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = ptr;
      2'd1:    bus_rdata = data_rd;
      2'd2:    bus_rdata = gstat;
      default: bus_rdata = gen;
    endcase
  end

  generate
    for (genvar g = 0; g < NP; g++) begin : g_pa
      assign play_addr[g*32 +: 32] = pbase[g] + {16'd0, pofs[g]};
    end
    for (genvar g = 0; g < NR; g++) begin : g_ra
      assign rec_addr[g*32 +: 32] = rbase[g] + {16'd0, rofs[g]};
    end
  endgenerate
endmodule

// File: rtl/audio_ptr_engine_chk.sv
module audio_ptr_engine_chk #(
  parameter int FB = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic        tick0,
  input logic        run0,
  input logic [15:0] ofs0,
  input logic [15:0] size0,
  input logic [31:0] addr0,
  input logic [31:0] status,
  input logic [31:0] enable,
  input logic        gsum
);
  wire [16:0] nxt0 = {1'b0, ofs0} + 17'(FB);

  assert_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run0 && tick0 && !bus_wr && nxt0 < {1'b0, size0}) |=> (ofs0 == $past(ofs0) + 16'(FB)));

  assert_stopped_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run0 && !bus_wr) |=> $stable(addr0));

  assert_wrap_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run0 && tick0 && !bus_wr && nxt0 >= {1'b0, size0}) |=> (ofs0 == 16'd0 && status[4]));

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && !bus_wr) |=> status[0]);

  assert_summary_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status & enable)) |=> gsum);

  assert_summary_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gsum && !bus_wr) |=> gsum);
endmodule

bind audio_ptr_engine audio_ptr_engine_chk #(.FB(FRAME_BYTES)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .tick0(play_tick[0]), .run0(prun[0]),
  .ofs0(pofs[0]), .size0(psize[0]), .addr0(play_addr[31:0]), .status(ais),
  .enable(aie), .gsum(gsum)
);

// File: tb/audio_ptr_engine_tb_top.sv
`timescale 1ns/1ps
module audio_ptr_engine_tb_top;
  logic         clk = 0;
  logic         rst_n = 0;
  logic [1:0]   bus_addr = 0;
  logic         bus_wr = 0;
  logic [31:0]  bus_wdata = 0;
  logic [31:0]  bus_rdata;
  logic [3:0]   play_tick = 0;
  logic [3:0]   rec_tick = 0;
  logic [127:0] play_addr;
  logic [127:0] rec_addr;
  logic         irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  audio_ptr_engine dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .play_tick(play_tick), .rec_tick(rec_tick),
    .play_addr(play_addr), .rec_addr(rec_addr), .irq(irq)
  );

  int unsigned mpb [4], mps [4], mpo [4], mrb [4], mrs [4], mro [4];
  int unsigned mptr, mgen, mais, maie, mprun, mrrun;
  bit mgs;

  always @(posedge clk) begin
    int unsigned evt, clr, n, h, rg, ch;
    bit pend;
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        mpb[i] = 0; mps[i] = 0; mpo[i] = 0; mrb[i] = 0; mrs[i] = 0; mro[i] = 0;
      end
      mptr = 0; mgen = 0; mais = 0; maie = 0; mprun = 0; mrrun = 0; mgs = 0;
    end else begin
      evt = 0; clr = 0;
      pend = (mais & maie) != 0;
      for (int i = 0; i < 4; i++) begin
        if (mprun[i] && play_tick[i]) begin
          n = mpo[i] + 4; h = mps[i] / 2;
          if (mpo[i] < h && n >= h) evt |= 1 << i;
          if (n >= mps[i]) begin evt |= 1 << (4 + i); mpo[i] = 0; end else mpo[i] = n;
        end
        if (mrrun[i] && rec_tick[i]) begin
          n = mro[i] + 4; h = mrs[i] / 2;
          if (mro[i] < h && n >= h) evt |= 1 << (16 + i);
          if (n >= mrs[i]) begin evt |= 1 << (20 + i); mro[i] = 0; end else mro[i] = n;
        end
      end
      if (bus_wr) begin
        rg = mptr >> 16; ch = mptr & 16'hffff;
        case (bus_addr)
          2'd0: mptr = bus_wdata;
          2'd2: if (bus_wdata[8]) mgs = 0;
          2'd3: mgen = bus_wdata;
          default: begin
            if (rg == 'h10) begin mprun = bus_wdata & 'hf; mrrun = (bus_wdata >> 8) & 'hf; end
            if (rg == 'h11) maie = bus_wdata & 32'h00ff_00ff;
            if (rg == 'h12) clr = bus_wdata;
            if (ch < 4) begin
              case (rg)
                'h0: mpb[ch] = bus_wdata;
                'h1: mps[ch] = bus_wdata >> 16;
                'h2: mpo[ch] = bus_wdata & 'hffff;
                'h4: mrb[ch] = bus_wdata;
                'h5: mrs[ch] = bus_wdata >> 16;
                'h6: mro[ch] = bus_wdata & 'hffff;
                default: ;
              endcase
            end
          end
        endcase
      end
      mais = (mais & ~clr) | evt;
      mgs = mgs || pend;
    end
  end

  function automatic int unsigned mread(input logic [1:0] a);
    int unsigned rg, ch;
    rg = mptr >> 16; ch = mptr & 16'hffff;
    case (a)
      2'd0: return mptr;
      2'd2: return mgs ? 32'h100 : 0;
      2'd3: return mgen;
      default: begin
        if (rg == 'h10) return mprun | (mrrun << 8);
        if (rg == 'h11) return maie;
        if (rg == 'h12) return mais;
        if (ch >= 4) return 0;
        case (rg)
          'h0: return mpb[ch];
          'h1: return mps[ch] << 16;
          'h2: return mpo[ch];
          'h4: return mrb[ch];
          'h5: return mrs[ch] << 16;
          'h6: return mro[ch];
          default: return 0;
        endcase
      end
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int i = 0; i < 4; i++) begin
        checks++;
        if (play_addr[i*32 +: 32] !== mpb[i] + mpo[i]) begin
          fails++;
          $display("FAIL R3 play_addr ch%0d act %h exp %h", i, play_addr[i*32 +: 32], mpb[i] + mpo[i]);
        end
        checks++;
        if (rec_addr[i*32 +: 32] !== mrb[i] + mro[i]) begin
          fails++;
          $display("FAIL R3 rec_addr ch%0d act %h exp %h", i, rec_addr[i*32 +: 32], mrb[i] + mro[i]);
        end
      end
      checks++;
      if (irq !== (mgs && mgen[8])) begin
        fails++;
        $display("FAIL R9 irq act %b exp %b", irq, mgs && mgen[8]);
      end
      checks++;
      if (bus_rdata !== mread(bus_addr)) begin
        fails++;
        $display("FAIL R1 bus_rdata addr %0d act %h exp %h", bus_addr, bus_rdata, mread(bus_addr));
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wr = 1; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic wreg(input int unsigned rg, input int unsigned ch, input logic [31:0] d);
    wr(2'd0, (rg << 16) | ch);
    wr(2'd1, d);
  endtask

  task automatic tick(input logic [3:0] pm, input logic [3:0] rm, input int cnt);
    for (int k = 0; k < cnt; k++) begin
      @(posedge clk); #1;
      play_tick = pm; rec_tick = rm;
      @(posedge clk); #1;
      play_tick = 0; rec_tick = 0;
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act %h exp %h", req, act, exp);
    end
  endtask

  task automatic rd_check(input logic [1:0] a, input logic [31:0] exp, input string req);
    @(posedge clk); #1;
    bus_addr = a; bus_wr = 0;
    @(negedge clk);
    chk(req, bus_rdata, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R10 irq", {31'd0, irq}, 0);
    chk("R10 play_addr0", play_addr[31:0], 0);
    rd_check(2'd0, 0, "R10 pointer");
    rd_check(2'd1, 0, "R10 data");
    rd_check(2'd2, 0, "R10 gstat");
    rd_check(2'd3, 0, "R10 genable");

    wreg('h0, 0, 32'h1000_0000);
    wreg('h1, 0, 32'h0010_abcd);
    rd_check(2'd1, 32'h0010_0000, "R2 size low half");
    rd_check(2'd0, 32'h0001_0000, "R1 pointer readback");
    wreg('h2, 0, 0);
    wreg('h4, 1, 32'h2000_0000);
    wreg('h5, 1, 32'h0020_0000);
    wreg('h0, 7, 32'hdead_0000);
    rd_check(2'd1, 0, "R1 channel out of range");
    wr(2'd0, 32'h0003_0000);
    rd_check(2'd1, 0, "R1 unknown register");
    wreg('h11, 0, 32'h0000_0010);
    wr(2'd3, 32'h0000_0100);
    rd_check(2'd3, 32'h0000_0100, "R9 genable readback");
    wreg('h10, 0, 32'h0000_0201);
    rd_check(2'd1, 32'h0000_0201, "R4 run readback");

    tick(4'b0001, 0, 2);
    @(negedge clk);
    chk("R3 play_addr after 2 frames", play_addr[31:0], 32'h1000_0008);
    wr(2'd0, 32'h0012_0000);
    rd_check(2'd1, 32'h0000_0001, "R5 half flag");
    tick(4'b0001, 0, 2);
    rd_check(2'd1, 32'h0000_0011, "R6 full flag");
    @(negedge clk);
    chk("R6 offset wrapped", play_addr[31:0], 32'h1000_0000);
    rd_check(2'd2, 32'h0000_0100, "R8 summary set");
    chk("R9 irq raised", {31'd0, irq}, 1);
    wr(2'd2, 32'h0000_0100);
    rd_check(2'd2, 32'h0000_0100, "R8 clear blocked while pending");
    wr(2'd1, 32'h0000_0010);
    rd_check(2'd1, 32'h0000_0001, "R7 w1c clears only written bits");
    wr(2'd2, 32'h0000_0100);
    rd_check(2'd2, 0, "R8 summary cleared");
    chk("R9 irq dropped", {31'd0, irq}, 0);

    tick(0, 4'b0010, 8);
    wr(2'd0, 32'h0012_0000);
    rd_check(2'd1, 32'h0022_0001, "R7 record flags recorded while disabled");
    rd_check(2'd2, 0, "R8 disabled flags give no summary");
    chk("R5 rec_addr wrapped", rec_addr[63:32], 32'h2000_0000);

    tick(4'b0001, 0, 1);
    wreg('h10, 0, 0);
    tick(4'b1111, 4'b1111, 3);
    @(negedge clk);
    chk("R4 stopped channel holds", play_addr[31:0], 32'h1000_0004);

    wreg('h10, 0, 32'h0000_0001);
    wr(2'd0, 32'h0002_0000);
    @(posedge clk); #1;
    bus_addr = 2'd1; bus_wr = 1; bus_wdata = 0; play_tick = 4'b0001;
    @(posedge clk); #1;
    bus_wr = 0; play_tick = 0;
    rd_check(2'd1, 0, "R2 offset write beats advance");
    tick(4'b0001, 0, 1);
    rd_check(2'd1, 4, "R3 offset readback after one frame");

    repeat (4) @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule